// File: doc/BRIEF.md
# Pipelined carry-save tree multiplier

This block multiplies an unsigned multiplicand by an unsigned 8-bit multiplier. It accepts a fresh operand pair on every clock cycle and returns the full-width product four cycles later. The multiplier has eight bits. Each of its bits gates one shifted copy of the multiplicand, which gives eight rows. The rows are reduced by a tree of three-input carry-save adders, and a single carry-propagate adder forms the final result.

The four pipeline stages do the following:
- Stage one forms all eight rows in parallel.
- Stage two uses two levels of carry-save adders, four adders in all, to cut the eight rows down to four numbers.
- Stage three uses two more carry-save adders to cut the four numbers down to a sum word and a carry word.
- Stage four adds the sum and carry words with a carry-propagate adder.

A valid flag travels next to the data through every stage. A user asserts `in_valid` together with an operand pair and takes `out_prod` in any cycle where `out_valid` is high. The multiplicand width is a parameter. The multiplier width is fixed at eight, because the shape of the tree depends on it.

Top module: `csa_tree_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product of the `in_a` and `in_b` that were accepted with `in_valid` four cycles earlier.
- R2: `out_valid` goes high exactly four rising edges after a cycle in which `in_valid` was high, once for each accepted pair.
- R3: Pairs accepted on consecutive cycles give products on consecutive cycles, in the order they were accepted, with no gap.
- R4: While `rst_n` is low, and for the first four edges after it rises, `out_valid` stays low.
- R5: Row j is the multiplicand if bit j of `in_b` is 1 (bit 0 is the least significant) and zero otherwise, shifted left by j. So a zero operand on either side gives a zero product, and a multiplier with only bit j set gives `in_a` shifted left by j.
- R6: All-ones operands give the largest product, (2^AW-1)*255, which is 65025 for AW = 8. This case exercises every carry path of the tree and of the final adder.
- R7: A cycle with `in_valid` low gives `out_valid` low four edges later. It does not disturb the products of the pairs accepted before or after it.
- R8: The parameter AW sets the width of the multiplicand. The product is then AW+8 bits wide, and R1 holds at that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_a` and `in_b` for this cycle |
| in_a | input | AW | Unsigned multiplicand |
| in_b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | Qualifies `out_prod` |
| out_prod | output | AW+8 | Unsigned product |

## Verification
The bench builds two instances that share the same stimulus:
- The first uses the default AW = 8. It gives the full 16-bit product range, including the all-ones corner where every carry-save column and the final adder carry at once.
- The second uses AW = 4. A multiplicand of a different width from the multiplier shows that the row widths and the 12-bit product follow the parameter rather than a fixed eight-by-eight layout.

For both instances the stimulus mixes the following, and tracks the bubble pattern on the valid flag cycle by cycle:
- directed single-bit multipliers
- zero operands
- back-to-back bursts
- idle gaps

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;
  // Number of multiplier bits, and so the number of rows the tree reduces.
  localparam int ROWS    = 8;
  // Rising edges from the input register to the output register.
  localparam int LATENCY = 4;
endpackage

// File: rtl/pp_rows.sv
module pp_rows #(
  parameter int AW = 8,
  parameter int PW = AW + mulpipe_pkg::ROWS
) (
  input  logic [AW-1:0]                        a,
  input  logic [mulpipe_pkg::ROWS-1:0]         b,
  output logic [mulpipe_pkg::ROWS-1:0][PW-1:0] rows
);
  localparam int ROWS = mulpipe_pkg::ROWS;

  logic [PW-1:0] a_ext;
  assign a_ext = PW'(a);

  // Row j: the multiplicand gated by bit j of b, placed j bits up.
  for (genvar j = 0; j < ROWS; j++) begin : g_row
    assign rows[j] = b[j] ? (a_ext << j) : '0;
  end
endmodule

// File: rtl/cs_adder.sv
module cs_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  // The carry word is weighted one bit up, so its bit 0 is always zero.
  assign s = x ^ y ^ z;
  assign c = ((x & y) | (y & z) | (x & z)) << 1;
endmodule

// File: rtl/cp_adder.sv
module cp_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  assign sum = x + y;
endmodule

// File: rtl/csa_tree_mul.sv
module csa_tree_mul #(
  parameter  int AW = 8,
  localparam int PW = AW + mulpipe_pkg::ROWS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [AW-1:0]                in_a,
  input  logic [mulpipe_pkg::ROWS-1:0] in_b,
  output logic                         out_valid,
  output logic [PW-1:0]                out_prod
);
  localparam int ROWS = mulpipe_pkg::ROWS;
  localparam int LAT  = mulpipe_pkg::LATENCY;

  // ---------------- stage 1: form the rows ----------------
  logic [ROWS-1:0][PW-1:0] rows_d, rows_q;
  logic                    v1_q;

  pp_rows #(.AW(AW), .PW(PW)) u_rows (
    .a    (in_a),
    .b    (in_b),
    .rows (rows_d)
  );

  // ---------------- stage 2: eight rows down to four ----------------
  logic [PW-1:0] l1_s0, l1_c0, l1_s1, l1_c1;
  logic [3:0][PW-1:0] quad_d, quad_q;
  logic               v2_q;

  cs_adder #(.W(PW)) u_l1a (.x(rows_q[0]), .y(rows_q[1]), .z(rows_q[2]),
                            .s(l1_s0), .c(l1_c0));
  cs_adder #(.W(PW)) u_l1b (.x(rows_q[3]), .y(rows_q[4]), .z(rows_q[5]),
                            .s(l1_s1), .c(l1_c1));
  cs_adder #(.W(PW)) u_l2a (.x(l1_s0), .y(l1_c0), .z(l1_s1),
                            .s(quad_d[0]), .c(quad_d[1]));
  cs_adder #(.W(PW)) u_l2b (.x(l1_c1), .y(rows_q[6]), .z(rows_q[7]),
                            .s(quad_d[2]), .c(quad_d[3]));

  // ---------------- stage 3: four numbers down to two ----------------
  logic [PW-1:0] l3_s, l3_c;
  logic [1:0][PW-1:0] pair_d, pair_q;
  logic               v3_q;

  cs_adder #(.W(PW)) u_l3a (.x(quad_q[0]), .y(quad_q[1]), .z(quad_q[2]),
                            .s(l3_s), .c(l3_c));
  cs_adder #(.W(PW)) u_l3b (.x(l3_s), .y(l3_c), .z(quad_q[3]),
                            .s(pair_d[0]), .c(pair_d[1]));

  // ---------------- stage 4: carry-propagate add ----------------
  logic [PW-1:0] prod_d, prod_q;
  logic          v4_q;

  cp_adder #(.W(PW)) u_cpa (.x(pair_q[0]), .y(pair_q[1]), .sum(prod_d));

  // ---------------- valid pipeline (reset) ----------------
  logic v1_d, v2_d, v3_d, v4_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
    v3_d = v2_q;
    v4_d = v3_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      v4_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
      v4_q <= v4_d;
    end
  end

  // ---------------- data pipeline (no reset, enabled by valid) ----------------
  always_ff @(posedge clk) begin
    if (in_valid) rows_q <= rows_d;
    if (v1_q)     quad_q <= quad_d;
    if (v2_q)     pair_q <= pair_d;
    if (v3_q)     prod_q <= prod_d;
  end

  assign out_valid = v4_q;
  assign out_prod  = prod_q;

  // ---------------- assertions ----------------
  logic [2:0] since_rst_d, since_rst_q;
  logic [PW-1:0] ref_prod, quad_total, pair_total;

  always_comb begin
    since_rst_d = (since_rst_q == 3'(LAT)) ? since_rst_q : since_rst_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= 3'd0;
    else        since_rst_q <= since_rst_d;
  end

  assign ref_prod   = PW'(in_a) * PW'(in_b);
  assign quad_total = quad_q[0] + quad_q[1] + quad_q[2] + quad_q[3];
  assign pair_total = pair_q[0] + pair_q[1];

  // R1 and R8: the product is right at the parameter width.
  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod == $past(ref_prod, 4));

  // R1: the stage-3 carry-save reduction keeps the sum held in stage 2.
  p_cs_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v3_q |-> pair_total == $past(quad_total));

  // R2, R3, R7: out_valid repeats in_valid four edges later, bubbles included.
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q == 3'(LAT)) |-> out_valid == $past(in_valid, 4));

  // R4: no output until four edges have passed since reset.
  p_idle_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < 3'(LAT)) |-> !out_valid);
endmodule

// File: tb/csa_tree_mul_bench.sv
`timescale 1ns/1ps
module csa_tree_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_a = '0;
  logic [7:0]  in_b = '0;
  logic        out_valid;
  logic [15:0] out_prod;
  logic        out_valid_n;
  logic [11:0] out_prod_n;

  always #2 clk = ~clk;

  csa_tree_mul u_csa_tree_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod));

  csa_tree_mul #(.AW(4)) u_csa_tree_mul_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a[3:0]), .in_b(in_b), .out_valid(out_valid_n), .out_prod(out_prod_n));

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    sv [4];
  logic [7:0] sa [4];
  logic [7:0] sb [4];
  string st [4];

  function automatic logic [31:0] model(logic [7:0] a, logic [7:0] b, int aw);
    logic [31:0] am;
    am = 32'(a) & ((32'd1 << aw) - 32'd1);
    return am * 32'(b);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs against the pair driven four negedges ago,
  // then drive the next pair.
  task automatic step(bit v, logic [7:0] a, logic [7:0] b, string tag);
    @(negedge clk);
    check({tag, " valid"}, 32'(out_valid), 32'(sv[3]));
    check("R8 valid (AW=4)", 32'(out_valid_n), 32'(sv[3]));
    if (sv[3] && out_valid) begin
      check(st[3], 32'(out_prod), model(sa[3], sb[3], 8));
      check("R8 product (AW=4)", 32'(out_prod_n), model(sa[3], sb[3], 4));
    end
    for (int k = 3; k > 0; k--) begin
      sv[k] = sv[k-1]; sa[k] = sa[k-1]; sb[k] = sb[k-1]; st[k] = st[k-1];
    end
    sv[0] = v; sa[0] = a; sb[0] = b; st[0] = tag;
    in_valid = v; in_a = a; in_b = b;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_junk;
    seed_junk = $urandom(32'd4242);
    for (int k = 0; k < 4; k++) begin
      sv[k] = 1'b0; sa[k] = '0; sb[k] = '0; st[k] = "R4";
    end
    // R4: held in reset, drive valid high to show it has no effect yet
    in_valid = 1'b1; in_a = 8'hFF; in_b = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 valid in reset", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R4: four idle cycles after release (slots tagged R4)
    // R5: zero operands and single-bit multipliers
    step(1'b1, 8'h00, 8'h5A, "R5 zero a");
    step(1'b1, 8'hC3, 8'h00, "R5 zero b");
    for (int j = 0; j < 8; j++) step(1'b1, 8'hB7, 8'(1 << j), "R5 single bit");
    // R6: all ones, back to back
    step(1'b1, 8'hFF, 8'hFF, "R6 all ones");
    step(1'b1, 8'hFF, 8'hFF, "R6 all ones");
    step(1'b1, 8'hFF, 8'h80, "R6 top bit");
    // R7: bubbles, with noise on the data inputs
    step(1'b0, 8'hAA, 8'h55, "R7 bubble");
    step(1'b0, 8'h55, 8'hAA, "R7 bubble");
    step(1'b1, 8'h81, 8'h7E, "R7 after bubble");
    step(1'b0, 8'hFF, 8'hFF, "R7 bubble");
    step(1'b1, 8'h01, 8'h01, "R7 after bubble");
    // R1 and R2: random pairs with random gaps
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), "R1 R2 random");
    // R3: dense burst
    for (int k = 0; k < 40; k++)
      step(1'b1, 8'($urandom), 8'($urandom), "R3 burst");
    // drain
    for (int k = 0; k < 6; k++) step(1'b0, 8'h00, 8'h00, "R7 drain");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule